// File: doc/BRIEF.md
# Load-Use Hazard Stall Unit

This block sits in the decode stage of a five-stage in-order pipeline that already forwards ALU results to the execute stage. Forwarding cannot cover one case: a memory load in EX whose data is only available after the MEM stage, while the instruction in ID needs that register as an operand. The block detects that pairing. For that one cycle it stops the program counter, holds the IF/ID register, and tells the ID/EX register to take a bubble whose control bits are all zero.

The decision is purely combinational from the ID-stage source indices and their use flags, and from the destination, write-enable and memory-read flag held in ID/EX. On the cycle after a stall the load has moved on to MEM and the bubble sits in EX, so the same pair never stalls twice. The dependent instruction reaches EX exactly one cycle later than it would without the hazard. If one unrelated instruction separates the load from its consumer, no stall occurs.

Top module: `load_use_stall_unit`

## Requirements
- R1: When ex_mem_rd_i=1, ex_reg_we_i=1, ex_dst_idx_i is nonzero, source 0 (id_src_idx_i bits [REG_AW-1:0]) has id_src_used_i[0]=1 and equals ex_dst_idx_i, the outputs are pc_we_o=0, ifid_hold_o=1, idex_bubble_o=1 in the same cycle.
- R2: The same stall is raised when source 1 (id_src_idx_i bits [2*REG_AW-1:REG_AW]) with id_src_used_i[1]=1 matches, including at the largest register index.
- R3: With ex_mem_rd_i=0 no stall is raised even if a used source matches the destination (pc_we_o=1, ifid_hold_o=0, idex_bubble_o=0).
- R4: With ex_reg_we_i=0 no stall is raised.
- R5: A destination index of 0 never causes a stall, even when a used source is also 0.
- R6: A matching source whose use flag is 0 does not cause a stall.
- R7: The three outputs always agree: pc_we_o is the inverse of ifid_hold_o, and idex_bubble_o equals ifid_hold_o.
- R8: In a pipeline running a load followed directly by a dependent instruction, the PC and IF/ID stay frozen for exactly one cycle, ID/EX holds a bubble with register write and memory read both 0 in the next cycle, and the dependent instruction enters EX one cycle late.
- R9: In a pipeline running a load, one unrelated instruction, and then a consumer of the load, no stall occurs and the PC advances every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_src_idx_i | input | NUM_SRC*REG_AW | Source register indices of the ID instruction, source 0 in the low bits |
| id_src_used_i | input | NUM_SRC | Per-source flag: the ID instruction actually reads that source |
| ex_dst_idx_i | input | REG_AW | Destination index held in ID/EX |
| ex_reg_we_i | input | 1 | Register write enable held in ID/EX |
| ex_mem_rd_i | input | 1 | Memory-read flag held in ID/EX (instruction is a load) |
| pc_we_o | output | 1 | PC write enable, low during a stall |
| ifid_hold_o | output | 1 | IF/ID hold, high during a stall |
| idex_bubble_o | output | 1 | Zero the controls loaded into ID/EX, high during a stall |

## Verification
The assertions check on every evaluation that a qualifying load-to-source match always raises the stall. They also check that any stall is backed by a load with write enable, a nonzero destination and a matching used source, and that the three outputs stay mutually consistent. The bench's pipeline model is the only place the timing can be seen. That model shows that the stall lasts one cycle, that the bubble carries zeroed controls, that the consumer reaches EX one cycle late, and that an intervening instruction removes the stall.

// File: rtl/lus_pkg.sv
package lus_pkg;
  parameter int unsigned REG_AW_DEF  = 5;
  parameter int unsigned NUM_SRC_DEF = 2;

  typedef struct packed {
    logic pc_we;
    logic ifid_hold;
    logic idex_bubble;
  } stall_ctrl_t;
endpackage

// File: rtl/lus_producer_qual.sv
// Qualifies the ID/EX instruction as a load that will write a real register.
module lus_producer_qual #(
  parameter int unsigned REG_AW = 5
) (
  input  logic [REG_AW-1:0] dst_idx_i,
  input  logic              reg_we_i,
  input  logic              mem_rd_i,
  output logic              load_dst_valid_o
);
  always_comb load_dst_valid_o = mem_rd_i && reg_we_i && (dst_idx_i != '0);
endmodule

// File: rtl/lus_src_match.sv
module lus_src_match #(
  parameter int unsigned REG_AW = 5
) (
  input  logic [REG_AW-1:0] src_idx_i,
  input  logic              src_used_i,
  input  logic [REG_AW-1:0] dst_idx_i,
  input  logic              dst_valid_i,
  output logic              hit_o
);
  always_comb hit_o = dst_valid_i && src_used_i && (src_idx_i == dst_idx_i);
endmodule

// File: rtl/lus_stall_ctrl.sv
module lus_stall_ctrl
  import lus_pkg::*;
#(
  parameter int unsigned NUM_SRC = 2
) (
  input  logic [NUM_SRC-1:0] hit_i,
  output stall_ctrl_t        ctrl_o
);
  logic stall;
  always_comb begin
    stall              = |hit_i;
    ctrl_o.pc_we       = ~stall;
    ctrl_o.ifid_hold   = stall;
    ctrl_o.idex_bubble = stall;
  end
endmodule

// File: rtl/load_use_stall_unit.sv
module load_use_stall_unit
  import lus_pkg::*;
#(
  parameter int unsigned REG_AW  = REG_AW_DEF,
  parameter int unsigned NUM_SRC = NUM_SRC_DEF
) (
  input  logic [NUM_SRC*REG_AW-1:0] id_src_idx_i,
  input  logic [NUM_SRC-1:0]        id_src_used_i,
  input  logic [REG_AW-1:0]         ex_dst_idx_i,
  input  logic                      ex_reg_we_i,
  input  logic                      ex_mem_rd_i,
  output logic                      pc_we_o,
  output logic                      ifid_hold_o,
  output logic                      idex_bubble_o
);
  logic               load_dst_valid;
  logic [NUM_SRC-1:0] src_hit;
  stall_ctrl_t        ctrl;

  lus_producer_qual #(.REG_AW(REG_AW)) u_qual (
    .dst_idx_i        (ex_dst_idx_i),
    .reg_we_i         (ex_reg_we_i),
    .mem_rd_i         (ex_mem_rd_i),
    .load_dst_valid_o (load_dst_valid)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    lus_src_match #(.REG_AW(REG_AW)) u_match (
      .src_idx_i   (id_src_idx_i[g*REG_AW +: REG_AW]),
      .src_used_i  (id_src_used_i[g]),
      .dst_idx_i   (ex_dst_idx_i),
      .dst_valid_i (load_dst_valid),
      .hit_o       (src_hit[g])
    );
  end

  lus_stall_ctrl #(.NUM_SRC(NUM_SRC)) u_ctrl (
    .hit_i  (src_hit),
    .ctrl_o (ctrl)
  );

  assign pc_we_o       = ctrl.pc_we;
  assign ifid_hold_o   = ctrl.ifid_hold;
  assign idex_bubble_o = ctrl.idex_bubble;

  // Port-level checks against the inputs.
  always_comb begin
    logic any_match;
    any_match = 1'b0;
    for (int k = 0; k < NUM_SRC; k++) begin
      if (id_src_used_i[k] && id_src_idx_i[k*REG_AW +: REG_AW] == ex_dst_idx_i)
        any_match = 1'b1;
    end
    // Source 0 covers R1, source 1 covers R2.
    if (ex_mem_rd_i && ex_reg_we_i && ex_dst_idx_i != '0 && any_match) begin
      assert_hit_stalls_R1: assert (ifid_hold_o && idex_bubble_o && !pc_we_o)
        else $error("load-use match did not stall");
    end
    if (ifid_hold_o) begin
      assert_stall_needs_load_R3: assert (ex_mem_rd_i)
        else $error("stall without load");
      assert_stall_needs_we_R4: assert (ex_reg_we_i)
        else $error("stall without write enable");
      assert_stall_nonzero_dst_R5: assert (ex_dst_idx_i != '0)
        else $error("stall on index zero");
      assert_stall_used_match_R6: assert (any_match)
        else $error("stall without used matching source");
    end
    assert_outputs_agree_R7: assert ((pc_we_o != ifid_hold_o) && (idex_bubble_o == ifid_hold_o))
      else $error("stall outputs disagree");
  end
endmodule

// File: tb/load_use_stall_unit_test.sv
`timescale 1ns/1ps
module load_use_stall_unit_test;
  localparam int AW = 5;

  typedef struct packed {
    logic [7:0]    id;
    logic [AW-1:0] rd;
    logic [AW-1:0] rs1;
    logic [AW-1:0] rs2;
    logic          u1;
    logic          u2;
    logic          ld;
    logic          we;
  } ins_t;

  typedef struct {
    logic  pc_we;
    logic  hold;
    logic  bub;
    bit    pipe;
    int    pc;
    int    ifid_id;
    int    idex_id;
    string req;
  } exp_t;

  localparam ins_t NOP = '{id: 8'hFF, default: '0};
  localparam ins_t BUB = '{id: 8'hFE, default: '0};

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  int checks = 0;
  int errors = 0;
  exp_t sb[$];

  // direct stimulus
  logic [2*AW-1:0] d_src = '0;
  logic [1:0]      d_used = '0;
  logic [AW-1:0]   d_dst = '0;
  logic            d_we = 1'b0;
  logic            d_ld = 1'b0;

  // pipeline model
  logic       pipe_mode = 1'b0;
  logic       pipe_clr  = 1'b1;
  ins_t       imem [8];
  logic [7:0] pc;
  ins_t       ifid, idex;

  logic [2*AW-1:0] src_w;
  logic [1:0]      used_w;
  logic [AW-1:0]   dst_w;
  logic            we_w, ld_w;
  logic            pc_we, hold, bub;

  assign src_w  = pipe_mode ? {ifid.rs2, ifid.rs1} : d_src;
  assign used_w = pipe_mode ? {ifid.u2, ifid.u1}   : d_used;
  assign dst_w  = pipe_mode ? idex.rd : d_dst;
  assign we_w   = pipe_mode ? idex.we : d_we;
  assign ld_w   = pipe_mode ? idex.ld : d_ld;

  load_use_stall_unit #(.REG_AW(AW), .NUM_SRC(2)) uut (
    .id_src_idx_i  (src_w),
    .id_src_used_i (used_w),
    .ex_dst_idx_i  (dst_w),
    .ex_reg_we_i   (we_w),
    .ex_mem_rd_i   (ld_w),
    .pc_we_o       (pc_we),
    .ifid_hold_o   (hold),
    .idex_bubble_o (bub)
  );

  always_ff @(posedge clk) begin
    if (pipe_clr) begin
      pc   <= '0;
      ifid <= NOP;
      idex <= NOP;
    end else begin
      if (pc_we) pc <= pc + 8'd1;
      if (!hold) ifid <= imem[pc[2:0]];
      idex <= bub ? BUB : ifid;
    end
  end

  function automatic ins_t mk(int id, int rd, int rs1, int rs2,
                              bit u1, bit u2, bit ld, bit we);
    ins_t r;
    r.id = 8'(id); r.rd = AW'(rd); r.rs1 = AW'(rs1); r.rs2 = AW'(rs2);
    r.u1 = u1; r.u2 = u2; r.ld = ld; r.we = we;
    return r;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor
  exp_t m;
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      m = sb.pop_front();
      check({pc_we, hold, bub} == {m.pc_we, m.hold, m.bub}, m.req, "pc_we/hold/bubble",
            int'({pc_we, hold, bub}), int'({m.pc_we, m.hold, m.bub}));
      if (m.pipe) begin
        check(int'(pc) == m.pc, m.req, "pc", int'(pc), m.pc);
        check(int'(ifid.id) == m.ifid_id, m.req, "ifid id", int'(ifid.id), m.ifid_id);
        check(int'(idex.id) == m.idex_id, m.req, "idex id", int'(idex.id), m.idex_id);
        if (m.idex_id == 8'hFE)
          check(!idex.we && !idex.ld, m.req, "bubble controls",
                int'({idex.we, idex.ld}), 0);
      end
    end
  end

  task automatic drive(int s1, bit u1, int s2, bit u2, int rd, bit we, bit ld,
                       bit e_pc_we, bit e_hold, bit e_bub, string req);
    exp_t e;
    @(posedge clk); #1;
    d_src = {AW'(s2), AW'(s1)}; d_used = {u2, u1};
    d_dst = AW'(rd); d_we = we; d_ld = ld;
    e.pc_we = e_pc_we; e.hold = e_hold; e.bub = e_bub;
    e.pipe = 0; e.pc = 0; e.ifid_id = 0; e.idex_id = 0; e.req = req;
    sb.push_back(e);
  endtask

  task automatic pipe_start();
    @(posedge clk); #1;
    pipe_mode = 1'b1;
    pipe_clr  = 1'b1;
  endtask

  task automatic pipe_step(int e_pc, int e_ifid, int e_idex, bit stall, string req);
    exp_t e;
    @(posedge clk); #1;
    pipe_clr = 1'b0;
    e.pc_we = !stall; e.hold = stall; e.bub = stall;
    e.pipe = 1; e.pc = e_pc; e.ifid_id = e_ifid; e.idex_id = e_idex; e.req = req;
    sb.push_back(e);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 8; i++) imem[i] = NOP;
    repeat (3) @(posedge clk);

    // direct patterns; R7 is checked by comparing all three outputs each time
    drive(5, 1, 3, 1, 5, 1, 1, 0, 1, 1, "R1/R7 src0 match");
    drive(3, 1, 12, 1, 12, 1, 1, 0, 1, 1, "R2 src1 match");
    drive(31, 0, 31, 1, 31, 1, 1, 0, 1, 1, "R2 max index");
    drive(7, 1, 7, 1, 7, 1, 1, 0, 1, 1, "R1 both match");
    drive(5, 1, 3, 1, 5, 1, 0, 1, 0, 0, "R3 not a load");
    drive(5, 1, 5, 1, 5, 0, 1, 1, 0, 0, "R4 no write enable");
    drive(0, 1, 0, 1, 0, 1, 1, 1, 0, 0, "R5 index zero");
    drive(9, 0, 4, 1, 9, 1, 1, 1, 0, 0, "R6 src0 unused");
    drive(4, 1, 9, 0, 9, 1, 1, 1, 0, 0, "R6 src1 unused");
    drive(6, 1, 8, 1, 10, 1, 1, 1, 0, 0, "R7 no match");

    // load then dependent consumer
    for (int i = 0; i < 8; i++) imem[i] = mk(i + 10, 20, 21, 22, 1, 1, 0, 1);
    imem[0] = mk(0, 5, 1, 0, 1, 0, 1, 1);
    imem[1] = mk(1, 6, 5, 7, 1, 1, 0, 1);
    pipe_start();
    pipe_step(0, 8'hFF, 8'hFF, 0, "R8 reset state");
    pipe_step(1, 0, 8'hFF, 0, "R8 load in ID");
    pipe_step(2, 1, 0, 1, "R8 stall cycle");
    pipe_step(2, 1, 8'hFE, 0, "R8 frozen with bubble");
    pipe_step(3, 12, 1, 0, "R8 consumer in EX");
    pipe_step(4, 13, 12, 0, "R8 flow resumes");

    // load, unrelated, consumer
    for (int i = 0; i < 8; i++) imem[i] = mk(i + 10, 20, 21, 22, 1, 1, 0, 1);
    imem[0] = mk(0, 5, 1, 0, 1, 0, 1, 1);
    imem[1] = mk(1, 8, 9, 10, 1, 1, 0, 1);
    imem[2] = mk(2, 6, 5, 7, 1, 1, 0, 1);
    pipe_start();
    pipe_step(0, 8'hFF, 8'hFF, 0, "R9 reset state");
    pipe_step(1, 0, 8'hFF, 0, "R9 load in ID");
    pipe_step(2, 1, 0, 0, "R9 unrelated behind load");
    pipe_step(3, 2, 1, 0, "R9 consumer in ID");
    pipe_step(4, 13, 2, 0, "R9 consumer in EX");

    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule